// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block times the marks and spaces on a single, already demodulated infrared input line. A 16-bit prescaler divides the reference clock, and each prescaler rollover advances a pulse-width counter. The counter restarts on the input edges chosen by the host. Each time a timed pulse ends, the block writes the stored part of the count and the level of that pulse into a small receive FIFO, where the host collects it.

The host reaches the block through a plain register port. A write is a one-cycle strobe. A read is combinational from the address, and a read strobe at the FIFO address pops one word. The block keeps sticky status for counter overflow (timeout) and for FIFO overrun, flags a service request at a level the host selects, and drives one interrupt line from the enabled status bits.

The register map is: 0 control, 1 prescaler reload, 2 status (read only), 3 interrupt enables, 4 FIFO data (a read pops). Control bits: [0] receiver on, [1] FIFO on, [3:2] edge select, [4] service request on any entry, [5] suppress the timeout marker.

Top module: `ir_width_rx`

## Requirements
- R1: After reset the control, prescaler, status and enable registers read 0, the FIFO reads empty and `irq` is low.
- R2: With reload D, the counter gains one tick every D+1 clocks after a selected edge. A pulse of N clocks yields floor((N-1)/(D+1)) ticks. The FIFO word holds ticks>>2 in bits 15:0 and, in bit 16, the line level during the pulse that ended.
- R3: A read at address 4 returns the oldest word with bit 17 set. When the FIFO is empty it returns 0 and removes nothing. Words leave in the order they were written.
- R4: Edge select (control bits 3:2) picks 0 = no edges, 1 = falling, 2 = rising, 3 = both. The first selected edge after the receiver is enabled only starts timing and writes no word.
- R5: Status bit 4 (service request) is set when the FIFO holds at least DEPTH/2 words if control bit 4 is 0, and when it holds any word if control bit 4 is 1.
- R6: When the counter overflows, status bit 0 sets, and the word 0x1FFFF is queued unless control bit 5 is 1. The counter then holds until the next selected edge, which restarts it and queues nothing.
- R7: Status bit 0 stays set until control bit 0 is cleared. Toggling only the FIFO enable does not clear it.
- R8: A word arriving at a full FIFO is dropped and sets status bit 1. That bit stays set, even across a toggle of the receiver enable, until control bit 1 is cleared. Clearing control bit 1 also empties the FIFO.
- R9: `irq` is the OR of status bits 0, 1 and 4, each gated by the enable bit at the same position in register 3.
- R10: Status bit 2 (busy) is set from the first selected edge until the receiver is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_in | input | 1 | Demodulated infrared line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops at address 4) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 6-bit pulse counter and an 8-entry FIFO. With the small counter, overflow takes only 64 ticks, so the timeout marker, the saturation and the restart without a word can all be reached at a prescaler reload of 0 in a short run. A reload of 1 checks the tick-to-width rounding. Eight entries let both service-request thresholds and the overrun drop be reached with a handful of pulses.

// File: rtl/ir_width_rx.sv
module ir_width_rx #(
  parameter int CNT_W = 18,
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);

  logic [5:0]       ctl;
  logic [15:0]      div, pre;
  logic [2:0]       ien;
  logic             s1, s2, prev;
  logic             meas, sat, tmo, ovr;
  logic [CNT_W-1:0] pw;
  logic [16:0]      mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             push;
  logic [16:0]      pword;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[15:6];

  wire rx_on   = ctl[0];
  wire fifo_on = ctl[1];
  wire rise    = s2 & ~prev;
  wire fall    = ~s2 & prev;
  wire hit     = rx_on & ((ctl[2] & fall) | (ctl[3] & rise));
  wire tick    = rx_on & meas & ~sat & (pre == 16'd0) & ~hit;
  wire ovf     = tick & (&pw);
  wire full    = cnt == (AW+1)'(DEPTH);
  wire wr_ok   = push & fifo_on & ~full;
  wire pop     = rd_en & (addr == 3'd4) & (cnt != '0);
  wire svc     = ctl[4] ? (cnt != '0) : (cnt >= (AW+1)'(DEPTH/2));

  wire [4:0] status = {svc, 1'b0, meas, ovr, tmo};

  always_comb begin
    push  = 1'b0;
    pword = '0;
    if (hit && meas && !sat) begin
      push  = 1'b1;
      pword = {prev, 16'(pw[CNT_W-1:2])};
    end else if (ovf && !ctl[5]) begin
      push  = 1'b1;
      pword = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; div <= '0; ien <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: ctl <= wdata[5:0];
        3'd1: div <= wdata;
        3'd3: ien <= {wdata[4], wdata[1:0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
    end else begin
      s1 <= ir_in; s2 <= s1; prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_on) begin
      meas <= 1'b0; sat <= 1'b0; tmo <= 1'b0;
      pw <= '0; pre <= div;
    end else if (hit) begin
      meas <= 1'b1; sat <= 1'b0;
      pw <= '0; pre <= div;
    end else if (tick) begin
      pre <= div;
      if (ovf) begin
        sat <= 1'b1; tmo <= 1'b1;
      end else begin
        pw <= pw + 1'b1;
      end
    end else if (meas && !sat) begin
      pre <= pre - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fifo_on) begin
      wp <= '0; rp <= '0; cnt <= '0; ovr <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)   rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(pop);
      if (push && full) ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= pword;
  end

  always_comb begin
    case (addr)
      3'd0: rdata = {26'd0, ctl};
      3'd1: rdata = {16'd0, div};
      3'd2: rdata = {27'd0, status};
      3'd3: rdata = {27'd0, ien[2], 2'b00, ien[1:0]};
      3'd4: rdata = (cnt != '0) ? {14'd0, 1'b1, mem[rp]} : 32'd0;
      default: rdata = 32'd0;
    endcase
  end

  assign irq = (tmo & ien[0]) | (ovr & ien[1]) | (svc & ien[2]);
endmodule

module ir_width_rx_chk #(
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rx_on,
  input logic                     fifo_on,
  input logic [$clog2(DEPTH):0]   cnt,
  input logic                     push,
  input logic                     rd_fifo,
  input logic                     ovr,
  input logic                     tmo,
  input logic                     sat
);
  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fifo && cnt == '0 && !push |=> cnt == '0);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && push && cnt == ($clog2(DEPTH)+1)'(DEPTH) |=> ovr);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && fifo_on |=> ovr);

  assert_tmo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && rx_on |=> tmo);

  assert_sat_after_tmo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> tmo);
endmodule

bind ir_width_rx ir_width_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_on(ctl[0]), .fifo_on(ctl[1]), .cnt(cnt),
  .push(push), .rd_fifo(rd_en && addr == 3'd4), .ovr(ovr), .tmo(tmo), .sat(sat)
);

// File: tb/ir_width_rx_bench.sv
`timescale 1ns/1ps
module ir_width_rx_bench;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #2.5 clk = ~clk;

  ir_width_rx #(.CNT_W(6), .DEPTH(DEPTH)) u_ir_width_rx (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int total = 0, fails = 0;
  int dv = 0, accum = 0;
  bit m_meas = 0, cur = 1;
  logic [1:0] esel = 2'd0;
  logic [17:0] q[$];
  logic [31:0] v;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; accum++;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] r);
    addr = a; rd_en = 1'b1; #1 r = rdata;
    @(negedge clk); rd_en = 1'b0; accum++;
  endtask

  task automatic cfg(logic [5:0] c);
    wr(3'd0, 16'd0);
    wr(3'd0, {10'd0, c});
    esel = c[3:2]; m_meas = 0;
  endtask

  // driver: models the expected FIFO words
  task automatic pulse(bit lvl, int n);
    bit sel;
    if (lvl != cur) begin
      sel = (esel == 2'd3) || (esel == 2'd2 && lvl) || (esel == 2'd1 && !lvl);
      if (sel) begin
        if (m_meas && q.size() < DEPTH)
          q.push_back({1'b1, cur, 16'(((accum - 1) / (dv + 1)) >> 2)});
        m_meas = 1; accum = 0;
      end
    end
    cur = lvl; ir_in = lvl;
    repeat (n) @(negedge clk);
    accum += n;
  endtask

  task automatic tog(int n);
    pulse(!cur, n);
  endtask

  // monitor: pops FIFO words and compares against the queue
  task automatic drain(string req);
    logic [17:0] e;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      rd(3'd4, v);
      if (!v[17]) break;
      e = (q.size() > 0) ? q.pop_front() : 18'h0;
      check(req, v, {14'd0, e});
    end
    check({req, " leftover"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); check("R1 ctl", v, 0);
    rd(3'd1, v); check("R1 div", v, 0);
    rd(3'd2, v); check("R1 status", v, 0);
    rd(3'd3, v); check("R1 ien", v, 0);
    rd(3'd4, v); check("R3 empty read", v, 0);
    check("R1 irq", irq, 0);

    // R2 / R4 both edges, reload 1
    dv = 1; wr(3'd1, 16'd1);
    cfg(6'h0F);
    pulse(0, 40); pulse(1, 30); pulse(0, 20); pulse(1, 12); pulse(0, 8);
    rd(3'd2, v); check("R10 busy", v[2], 1);
    check("R5 half full", v[4], 1);
    drain("R2 both edges");
    rd(3'd4, v); check("R3 empty again", v, 0);

    // R4 falling only
    cfg(6'h07);
    pulse(1, 10); pulse(0, 10); pulse(1, 15); pulse(0, 9); pulse(1, 6); pulse(0, 8);
    drain("R4 falling");

    // R4 rising only
    cfg(6'h0B);
    pulse(1, 10); pulse(0, 20); pulse(1, 5); pulse(0, 7); pulse(1, 8);
    drain("R4 rising");

    // R4 no edges
    cfg(6'h03);
    tog(10); tog(10); tog(10);
    rd(3'd2, v); check("R10 idle with no edges", v[2], 0);
    drain("R4 none");

    // R5 / R9 half-full threshold
    cfg(6'h0F); wr(3'd3, 16'h0010);
    tog(8); tog(8); tog(8); tog(8);
    rd(3'd2, v); check("R5 three words", v[4], 0);
    check("R9 irq low", irq, 0);
    tog(8);
    rd(3'd2, v); check("R5 four words", v[4], 1);
    check("R9 irq svc", irq, 1);
    drain("R5 half");
    rd(3'd2, v); check("R5 after drain", v[4], 0);

    // R5 any-entry threshold
    cfg(6'h1F);
    tog(8); tog(8);
    rd(3'd2, v); check("R5 one word", v[4], 1);
    drain("R5 any");
    rd(3'd2, v); check("R5 drained any", v[4], 0);

    // R8 overrun
    cfg(6'h0F); wr(3'd3, 16'h0002);
    tog(8);
    for (int i = 0; i < DEPTH + 1; i++) tog(8);
    rd(3'd2, v); check("R8 overrun set", v[1], 1);
    check("R9 irq ovr", irq, 1);
    drain("R8 first words kept");
    rd(3'd2, v); check("R8 sticky after drain", v[1], 1);
    wr(3'd0, 16'h000E); wr(3'd0, 16'h000F);
    rd(3'd2, v); check("R8 rx toggle keeps", v[1], 1);
    cfg(6'h0F);
    rd(3'd2, v); check("R8 cleared by fifo toggle", v[1], 0);

    // R6 / R7 timeout with marker, reload 0
    dv = 0; wr(3'd1, 16'd0);
    cfg(6'h0F); wr(3'd3, 16'h0001);
    tog(10);
    repeat (100) @(negedge clk);
    q.push_back(18'h3FFFF);
    rd(3'd2, v); check("R6 timeout set", v[0], 1);
    check("R9 irq tmo", irq, 1);
    m_meas = 0;
    tog(20); tog(6);
    drain("R6 marker then restart");
    wr(3'd0, 16'h000D); wr(3'd0, 16'h000F);
    rd(3'd2, v); check("R7 fifo toggle keeps", v[0], 1);
    wr(3'd0, 16'h000E); wr(3'd0, 16'h000F);
    rd(3'd2, v); check("R7 cleared by rx toggle", v[0], 0);

    // R6 marker suppressed
    cfg(6'h2F);
    tog(10);
    repeat (100) @(negedge clk);
    rd(3'd2, v); check("R6 timeout no marker", v[0], 1);
    drain("R6 no marker");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule